// File: doc/BRIEF.md
# Write-Miss Invalidation Acknowledgement Tracker

This block sits beside a processor on the requester side of a directory-based coherent memory system. Each store miss or writeback the processor issues takes one tracking entry, chosen by the processor's own transaction tag. For a store miss, the home node answers with an exclusive grant or an upgrade grant. That grant carries the number of invalidation acknowledgements still to come from other sharers. The acknowledgements travel over separate network paths, so some or all of them can arrive before the grant. The entry keeps a signed running balance. Each acknowledgement subtracts one, and the count carried by the grant is added when the grant lands. The processor receives one completion pulse, and only when the grant is in and the balance is back at zero. This keeps later accesses from becoming visible before the store has completed everywhere.

Interventions from the home for a line that has a store still in progress are held in a one-deep slot in that entry. They are handed back out on the cycle the entry closes. Interventions for a line that has a writeback in flight are discarded, because the writeback data already answers them. Interventions for lines the block does not track are passed straight on. A negative acknowledgement from the home frees the entry and asks the processor to retry.

Each entry is a four-state machine. The states are `E_IDLE`, `E_WR_WAIT` (store miss, grant not yet seen), `E_WR_ACKS` (grant seen, acknowledgements outstanding) and `E_WB_WAIT` (writeback awaiting its acknowledgement). The transitions are named as follows:
- T_ALLOC_WR: `E_IDLE`→`E_WR_WAIT`.
- T_ALLOC_WB: `E_IDLE`→`E_WB_WAIT`.
- T_GRANT_CLOSE: `E_WR_WAIT`→`E_IDLE`, taken when a grant brings the balance to zero.
- T_GRANT_OPEN: `E_WR_WAIT`→`E_WR_ACKS`, taken when a grant leaves the balance non-zero.
- T_NACK: `E_WR_WAIT`→`E_IDLE`.
- T_LAST_ACK: `E_WR_ACKS`→`E_IDLE`.
- T_WB_ACK: `E_WB_WAIT`→`E_IDLE`.

Top module: `ackc_collector`

## Requirements
- R1: While and after reset, every entry is idle and all outputs are zero.
- R2: A store-miss entry raises its bit of `done_o` (bit index = tag) exactly once. The pulse comes one cycle after the cycle in which both the grant has been received and the received acknowledgements equal the grant's count. It never comes earlier.
- R3: Acknowledgements that arrive before the grant are counted. If they already cover the grant's count, completion follows the grant by one cycle.
- R4: A grant with a count of zero and no early acknowledgements completes the entry one cycle after the grant. `rsp_kind` 0 (exclusive grant) and 1 (upgrade grant) behave identically.
- R5: A response with `rsp_kind` 2 (NACK) to a store-miss entry waiting for its grant frees the entry. It pulses `retry_o` for that tag and does not pulse `done_o`.
- R6: An intervention whose line matches a store-miss entry is not forwarded while that entry is open. It appears on `rel_o` with its line in `rel_line_o[tag*LINE_W +: LINE_W]`, in the same cycle as that entry's `done_o` or `retry_o`. This includes an intervention arriving in the entry's closing cycle.
- R7: An intervention for an entry whose slot is already full pulses `intv_nack_o` one cycle later.
- R8: An intervention whose line matches a writeback entry pulses `intv_drop_o` one cycle later and is never released. This takes priority over a matching store-miss entry.
- R9: A response with `rsp_kind` 3 (writeback ack) to a writeback entry pulses `wb_done_o` for that tag one cycle later and frees the entry.
- R10: An intervention that matches no open entry pulses `intv_fwd_o` one cycle later, with its line on `intv_fwd_line_o`.
- R11: An allocation to a busy tag is ignored. Responses and acknowledgements to an idle tag are ignored. A response kind that does not fit the entry's state is ignored.
- R12: The entries (four by default) run independently, and several may complete in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Open an entry |
| alloc_wb | input | 1 | 1 = writeback entry, 0 = store-miss entry |
| alloc_id | input | $clog2(N_ENT) | Tag of the entry to open |
| alloc_line | input | LINE_W | Line address of the transaction |
| rsp_valid | input | 1 | Home response present |
| rsp_kind | input | 2 | 0 exclusive grant, 1 upgrade grant, 2 NACK, 3 writeback ack |
| rsp_id | input | $clog2(N_ENT) | Tag the response belongs to |
| rsp_count | input | CNT_W | Invalidation acknowledgements to expect |
| ack_valid | input | 1 | One invalidation acknowledgement present |
| ack_id | input | $clog2(N_ENT) | Tag the acknowledgement belongs to |
| intv_valid | input | 1 | Intervention from the home present |
| intv_line | input | LINE_W | Line the intervention targets |
| done_o | output | N_ENT | Store completion pulse, one bit per tag |
| retry_o | output | N_ENT | Retry pulse after a NACK, one bit per tag |
| wb_done_o | output | N_ENT | Writeback completion pulse, one bit per tag |
| rel_o | output | N_ENT | Held intervention released, one bit per tag |
| rel_line_o | output | N_ENT*LINE_W | Line of each released intervention |
| intv_fwd_o | output | 1 | Intervention passed straight on |
| intv_fwd_line_o | output | LINE_W | Line of the passed-on intervention |
| intv_drop_o | output | 1 | Intervention discarded due to writeback |
| intv_nack_o | output | 1 | Intervention refused, slot full |

## Verification
The hardest situation to reach is an entry that closes in the same cycle as another event. The first case is a held intervention arriving exactly on the closing acknowledgement. The second is two entries finishing together, one on its last acknowledgement and one on a zero-count grant. Both need a store miss parked in the acknowledgement-wait state with a known balance. The stimulus gets there by opening entries, sending acknowledgements ahead of the grant, and then lining up the closing acknowledgement, grant and intervention in a single cycle. A behavioural model tracks the balances and slots and is compared on every clock.

// File: rtl/ackc_pkg.sv
package ackc_pkg;

    typedef enum logic [1:0] {
        E_IDLE    = 2'd0,
        E_WR_WAIT = 2'd1,
        E_WR_ACKS = 2'd2,
        E_WB_WAIT = 2'd3
    } ent_st_e;

    typedef enum logic [1:0] {
        RSP_EXCL  = 2'd0,
        RSP_UPG   = 2'd1,
        RSP_NACK  = 2'd2,
        RSP_WBACK = 2'd3
    } rsp_kind_e;

endpackage

// File: rtl/ackc_entry.sv
module ackc_entry
    import ackc_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_v,
    input  logic              alloc_wb,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              rsp_v,
    input  rsp_kind_e         rsp_kind,
    input  logic [CNT_W-1:0]  rsp_count,
    input  logic              ack_v,
    input  logic              defer_v,
    input  logic [LINE_W-1:0] intv_line,
    output logic              wr_busy,
    output logic              wb_busy,
    output logic              slot_full,
    output logic [LINE_W-1:0] line_q,
    output logic              done_q,
    output logic              retry_q,
    output logic              wbdone_q,
    output logic              rel_q,
    output logic [LINE_W-1:0] rel_line_q
);

    localparam int SW = CNT_W + 1;

    ent_st_e            st_q, st_d;
    logic signed [SW-1:0] bal_q, bal_d, bal_sum;
    logic [LINE_W-1:0]  line_d;
    logic               slot_q, slot_d;
    logic [LINE_W-1:0]  slot_line_q, slot_line_d;
    logic               grant_in, add_cnt;
    logic               ev_done, ev_retry, ev_wbdone, closing;
    logic               rel_d;
    logic [LINE_W-1:0]  rel_line_d;

    assign grant_in = rsp_v && ((rsp_kind == RSP_EXCL) || (rsp_kind == RSP_UPG));
    assign add_cnt  = grant_in && (st_q == E_WR_WAIT);

    // signed balance: acks subtract, the grant count adds
    always_comb begin
        bal_sum = bal_q - SW'(ack_v);
        if (add_cnt) begin
            bal_sum = bal_sum + SW'(rsp_count);
        end
    end

    // next state
    always_comb begin
        st_d      = st_q;
        bal_d     = bal_q;
        line_d    = line_q;
        ev_done   = 1'b0;
        ev_retry  = 1'b0;
        ev_wbdone = 1'b0;
        unique case (st_q)
            E_IDLE: begin
                if (alloc_v) begin
                    st_d   = alloc_wb ? E_WB_WAIT : E_WR_WAIT;   // T_ALLOC_WB / T_ALLOC_WR
                    bal_d  = '0;
                    line_d = alloc_line;
                end
            end
            E_WR_WAIT: begin
                if (rsp_v && (rsp_kind == RSP_NACK)) begin        // T_NACK
                    ev_retry = 1'b1;
                    st_d     = E_IDLE;
                    bal_d    = '0;
                end else if (grant_in) begin
                    if (bal_sum == '0) begin                      // T_GRANT_CLOSE
                        ev_done = 1'b1;
                        st_d    = E_IDLE;
                        bal_d   = '0;
                    end else begin                                // T_GRANT_OPEN
                        st_d  = E_WR_ACKS;
                        bal_d = bal_sum;
                    end
                end else begin
                    bal_d = bal_sum;
                end
            end
            E_WR_ACKS: begin
                if (bal_sum == '0) begin                          // T_LAST_ACK
                    ev_done = 1'b1;
                    st_d    = E_IDLE;
                    bal_d   = '0;
                end else begin
                    bal_d = bal_sum;
                end
            end
            E_WB_WAIT: begin
                if (rsp_v && (rsp_kind == RSP_WBACK)) begin      // T_WB_ACK
                    ev_wbdone = 1'b1;
                    st_d      = E_IDLE;
                end
            end
            default: st_d = E_IDLE;
        endcase
    end

    // deferred intervention slot
    always_comb begin
        closing     = ev_done || ev_retry;
        slot_d      = slot_q;
        slot_line_d = slot_line_q;
        rel_d       = closing && (slot_q || defer_v);
        rel_line_d  = slot_q ? slot_line_q : intv_line;
        if (closing) begin
            slot_d = 1'b0;
        end else if (defer_v && !slot_q && wr_busy) begin
            slot_d      = 1'b1;
            slot_line_d = intv_line;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= E_IDLE;
            bal_q       <= '0;
            line_q      <= '0;
            slot_q      <= 1'b0;
            slot_line_q <= '0;
        end else begin
            st_q        <= st_d;
            bal_q       <= bal_d;
            line_q      <= line_d;
            slot_q      <= slot_d;
            slot_line_q <= slot_line_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            retry_q    <= 1'b0;
            wbdone_q   <= 1'b0;
            rel_q      <= 1'b0;
            rel_line_q <= '0;
        end else begin
            done_q     <= ev_done;
            retry_q    <= ev_retry;
            wbdone_q   <= ev_wbdone;
            rel_q      <= rel_d;
            rel_line_q <= rel_d ? rel_line_d : '0;
        end
    end

    assign wr_busy   = (st_q == E_WR_WAIT) || (st_q == E_WR_ACKS);
    assign wb_busy   = (st_q == E_WB_WAIT);
    assign slot_full = slot_q;

endmodule

// File: rtl/ackc_intv_route.sv
module ackc_intv_route #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 16
) (
    input  logic                    intv_valid,
    input  logic [LINE_W-1:0]       intv_line,
    input  logic [N_ENT-1:0]        wr_busy,
    input  logic [N_ENT-1:0]        wb_busy,
    input  logic [N_ENT-1:0]        slot_full,
    input  logic [N_ENT*LINE_W-1:0] line_flat,
    output logic [N_ENT-1:0]        defer_vec,
    output logic                    drop,
    output logic                    nack,
    output logic                    fwd
);

    logic [N_ENT-1:0] wb_hit, wr_hit, wr_first;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_match
        logic same_line;
        assign same_line  = (line_flat[gi*LINE_W +: LINE_W] == intv_line);
        assign wb_hit[gi] = intv_valid && wb_busy[gi] && same_line;
        assign wr_hit[gi] = intv_valid && wr_busy[gi] && same_line;
    end

    always_comb begin
        wr_first  = wr_hit & (~wr_hit + N_ENT'(1));
        drop      = |wb_hit;
        nack      = !drop && |(wr_first & slot_full);
        defer_vec = drop ? '0 : (wr_first & ~slot_full);
        fwd       = intv_valid && !drop && (wr_hit == '0);
    end

endmodule

// File: rtl/ackc_collector.sv
module ackc_collector
    import ackc_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 16,
    parameter int CNT_W  = 4,
    localparam int IDW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic                    alloc_wb,
    input  logic [IDW-1:0]          alloc_id,
    input  logic [LINE_W-1:0]       alloc_line,
    input  logic                    rsp_valid,
    input  logic [1:0]              rsp_kind,
    input  logic [IDW-1:0]          rsp_id,
    input  logic [CNT_W-1:0]        rsp_count,
    input  logic                    ack_valid,
    input  logic [IDW-1:0]          ack_id,
    input  logic                    intv_valid,
    input  logic [LINE_W-1:0]       intv_line,
    output logic [N_ENT-1:0]        done_o,
    output logic [N_ENT-1:0]        retry_o,
    output logic [N_ENT-1:0]        wb_done_o,
    output logic [N_ENT-1:0]        rel_o,
    output logic [N_ENT*LINE_W-1:0] rel_line_o,
    output logic                    intv_fwd_o,
    output logic [LINE_W-1:0]       intv_fwd_line_o,
    output logic                    intv_drop_o,
    output logic                    intv_nack_o
);

    logic [N_ENT-1:0]        wr_busy, wb_busy, slot_full, defer_vec;
    logic [N_ENT*LINE_W-1:0] line_flat;
    logic                    r_drop, r_nack, r_fwd;
    rsp_kind_e               kind_e;

    assign kind_e = rsp_kind_e'(rsp_kind);

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        logic a_v, r_v, k_v;
        assign a_v = alloc_valid && (alloc_id == IDW'(gi));
        assign r_v = rsp_valid   && (rsp_id   == IDW'(gi));
        assign k_v = ack_valid   && (ack_id   == IDW'(gi));

        ackc_entry #(
            .LINE_W (LINE_W),
            .CNT_W  (CNT_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_v    (a_v),
            .alloc_wb   (alloc_wb),
            .alloc_line (alloc_line),
            .rsp_v      (r_v),
            .rsp_kind   (kind_e),
            .rsp_count  (rsp_count),
            .ack_v      (k_v),
            .defer_v    (defer_vec[gi]),
            .intv_line  (intv_line),
            .wr_busy    (wr_busy[gi]),
            .wb_busy    (wb_busy[gi]),
            .slot_full  (slot_full[gi]),
            .line_q     (line_flat[gi*LINE_W +: LINE_W]),
            .done_q     (done_o[gi]),
            .retry_q    (retry_o[gi]),
            .wbdone_q   (wb_done_o[gi]),
            .rel_q      (rel_o[gi]),
            .rel_line_q (rel_line_o[gi*LINE_W +: LINE_W])
        );
    end

    ackc_intv_route #(
        .N_ENT  (N_ENT),
        .LINE_W (LINE_W)
    ) u_route (
        .intv_valid (intv_valid),
        .intv_line  (intv_line),
        .wr_busy    (wr_busy),
        .wb_busy    (wb_busy),
        .slot_full  (slot_full),
        .line_flat  (line_flat),
        .defer_vec  (defer_vec),
        .drop       (r_drop),
        .nack       (r_nack),
        .fwd        (r_fwd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_fwd_o      <= 1'b0;
            intv_fwd_line_o <= '0;
            intv_drop_o     <= 1'b0;
            intv_nack_o     <= 1'b0;
        end else begin
            intv_fwd_o      <= r_fwd;
            intv_fwd_line_o <= r_fwd ? intv_line : '0;
            intv_drop_o     <= r_drop;
            intv_nack_o     <= r_nack;
        end
    end

endmodule

// File: rtl/ackc_checker.sv
module ackc_checker #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              intv_valid,
    input logic [LINE_W-1:0] intv_line,
    input logic [N_ENT-1:0]  done_o,
    input logic [N_ENT-1:0]  retry_o,
    input logic [N_ENT-1:0]  wb_done_o,
    input logic [N_ENT-1:0]  rel_o,
    input logic              intv_fwd_o,
    input logic [LINE_W-1:0] intv_fwd_line_o,
    input logic              intv_drop_o,
    input logic              intv_nack_o
);

    p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |=> ((done_o & $past(done_o)) == '0));

    p_no_done_on_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o & retry_o) == '0);

    p_release_on_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o & ~(done_o | retry_o)) == '0);

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({intv_fwd_o, intv_drop_o, intv_nack_o}));

    p_drop_from_intv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intv_drop_o |-> $past(intv_valid));

    p_wb_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done_o & (done_o | retry_o)) == '0);

    p_fwd_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        intv_fwd_o |-> (intv_fwd_line_o == $past(intv_line)));

endmodule

bind ackc_collector ackc_checker #(
    .N_ENT  (N_ENT),
    .LINE_W (LINE_W)
) u_ackc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .intv_valid      (intv_valid),
    .intv_line       (intv_line),
    .done_o          (done_o),
    .retry_o         (retry_o),
    .wb_done_o       (wb_done_o),
    .rel_o           (rel_o),
    .intv_fwd_o      (intv_fwd_o),
    .intv_fwd_line_o (intv_fwd_line_o),
    .intv_drop_o     (intv_drop_o),
    .intv_nack_o     (intv_nack_o)
);

// File: tb/ackc_collector_bench.sv
module ackc_collector_bench;

    localparam int N  = 4;
    localparam int LW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 0, alloc_wb = 0;
    logic [1:0]    alloc_id = 0;
    logic [LW-1:0] alloc_line = 0;
    logic          rsp_valid = 0;
    logic [1:0]    rsp_kind = 0, rsp_id = 0;
    logic [CW-1:0] rsp_count = 0;
    logic          ack_valid = 0;
    logic [1:0]    ack_id = 0;
    logic          intv_valid = 0;
    logic [LW-1:0] intv_line = 0;
    logic [N-1:0]  done_o, retry_o, wb_done_o, rel_o;
    logic [N*LW-1:0] rel_line_o;
    logic          intv_fwd_o, intv_drop_o, intv_nack_o;
    logic [LW-1:0] intv_fwd_line_o;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // model state: 0 idle, 1 store wait grant, 2 store wait acks, 3 writeback
    int m_st[N];
    int m_bal[N];
    int m_line[N];
    bit m_slot[N];
    int m_sline[N];

    always #10 clk = ~clk;

    ackc_collector u_ackc_collector (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_wb(alloc_wb), .alloc_id(alloc_id), .alloc_line(alloc_line),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_id(rsp_id), .rsp_count(rsp_count),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .intv_valid(intv_valid), .intv_line(intv_line),
        .done_o(done_o), .retry_o(retry_o), .wb_done_o(wb_done_o), .rel_o(rel_o),
        .rel_line_o(rel_line_o), .intv_fwd_o(intv_fwd_o), .intv_fwd_line_o(intv_fwd_line_o),
        .intv_drop_o(intv_drop_o), .intv_nack_o(intv_nack_o)
    );

    task automatic fail_line(string what, int act, int exp);
        fails++;
        $display("FAIL [%s] %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    endtask

    task automatic clear_inputs();
        alloc_valid = 0; alloc_wb = 0; rsp_valid = 0; ack_valid = 0; intv_valid = 0;
    endtask

    // one clock: model predicts, DUT runs, outputs compared after the edge
    task automatic step();
        bit [N-1:0] e_done = '0, e_retry = '0, e_wb = '0, e_rel = '0;
        int e_rline[N];
        bit e_fwd = 0, e_drop = 0, e_nack = 0;
        int e_fline = 0;
        int defer_j = -1;
        int o_st[N];
        bit ok = 1;
        for (int i = 0; i < N; i++) begin
            o_st[i] = m_st[i];
            e_rline[i] = 0;
        end
        if (intv_valid) begin
            bit hitwb = 0;
            int first = -1;
            for (int i = 0; i < N; i++)
                if (o_st[i] == 3 && m_line[i] == int'(intv_line)) hitwb = 1;
            for (int i = 0; i < N; i++)
                if (first < 0 && (o_st[i] == 1 || o_st[i] == 2) && m_line[i] == int'(intv_line)) first = i;
            if (hitwb) e_drop = 1;
            else if (first >= 0) begin
                if (m_slot[first]) e_nack = 1; else defer_j = first;
            end else begin
                e_fwd = 1; e_fline = int'(intv_line);
            end
        end
        for (int i = 0; i < N; i++) begin
            bit ak = ack_valid && (int'(ack_id) == i);
            bit rs = rsp_valid && (int'(rsp_id) == i);
            bit close = 0;
            int c;
            case (o_st[i])
                1: begin
                    if (rs && rsp_kind == 2) begin e_retry[i] = 1; close = 1; end
                    else if (rs && rsp_kind < 2) begin
                        c = m_bal[i] - int'(ak) + int'(rsp_count);
                        if (c == 0) begin e_done[i] = 1; close = 1; end
                        else begin m_st[i] = 2; m_bal[i] = c; end
                    end else m_bal[i] = m_bal[i] - int'(ak);
                end
                2: begin
                    c = m_bal[i] - int'(ak);
                    if (c == 0) begin e_done[i] = 1; close = 1; end
                    else m_bal[i] = c;
                end
                3: if (rs && rsp_kind == 3) begin e_wb[i] = 1; m_st[i] = 0; end
                default: if (alloc_valid && int'(alloc_id) == i) begin
                    m_st[i] = alloc_wb ? 3 : 1; m_bal[i] = 0;
                    m_line[i] = int'(alloc_line); m_slot[i] = 0;
                end
            endcase
            if (close) begin
                if (m_slot[i] || defer_j == i) begin
                    e_rel[i] = 1;
                    e_rline[i] = m_slot[i] ? m_sline[i] : int'(intv_line);
                end
                m_st[i] = 0; m_bal[i] = 0; m_slot[i] = 0;
            end else if (defer_j == i) begin
                m_slot[i] = 1; m_sline[i] = int'(intv_line);
            end
        end
        @(posedge clk);
        @(negedge clk);
        tests++;
        if (done_o != e_done)   begin ok = 0; fail_line("done_o", int'(done_o), int'(e_done)); end
        if (retry_o != e_retry) begin ok = 0; fail_line("retry_o", int'(retry_o), int'(e_retry)); end
        if (wb_done_o != e_wb)  begin ok = 0; fail_line("wb_done_o", int'(wb_done_o), int'(e_wb)); end
        if (rel_o != e_rel)     begin ok = 0; fail_line("rel_o", int'(rel_o), int'(e_rel)); end
        for (int i = 0; i < N; i++)
            if (e_rel[i] && int'(rel_line_o[i*LW +: LW]) != e_rline[i]) begin
                ok = 0; fail_line("rel_line_o", int'(rel_line_o[i*LW +: LW]), e_rline[i]);
            end
        if (intv_fwd_o != e_fwd)   begin ok = 0; fail_line("intv_fwd_o", int'(intv_fwd_o), int'(e_fwd)); end
        if (e_fwd && int'(intv_fwd_line_o) != e_fline) begin ok = 0; fail_line("intv_fwd_line_o", int'(intv_fwd_line_o), e_fline); end
        if (intv_drop_o != e_drop) begin ok = 0; fail_line("intv_drop_o", int'(intv_drop_o), int'(e_drop)); end
        if (intv_nack_o != e_nack) begin ok = 0; fail_line("intv_nack_o", int'(intv_nack_o), int'(e_nack)); end
        if (!ok) fails = fails + 0;
        clear_inputs();
    endtask

    task automatic set_alloc(int id, bit wb, int line);
        alloc_valid = 1; alloc_id = 2'(id); alloc_wb = wb; alloc_line = LW'(line);
    endtask
    task automatic set_rsp(int id, int kind, int cnt);
        rsp_valid = 1; rsp_id = 2'(id); rsp_kind = 2'(kind); rsp_count = CW'(cnt);
    endtask
    task automatic set_ack(int id);
        ack_valid = 1; ack_id = 2'(id);
    endtask
    task automatic set_intv(int line);
        intv_valid = 1; intv_line = LW'(line);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL [R2] watchdog: cycles=%0d expected below %0d", 20000, 20000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_bal[i] = 0; m_line[i] = 0; m_slot[i] = 0; m_sline[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        tests++;
        if ({done_o, retry_o, wb_done_o, rel_o, intv_fwd_o, intv_drop_o, intv_nack_o} != '0)
            fail_line("reset outputs", int'({done_o, retry_o, wb_done_o, rel_o}), 0);
        rst_n = 1;
        cur_req = "R1"; step();

        // R2: grant count 2, two acks afterwards
        cur_req = "R2";
        set_alloc(0, 0, 'h100); step();
        set_rsp(0, 0, 2); step();
        set_ack(0); step();
        set_ack(0); step();
        step();

        // R3: two early acks, then upgrade grant count 2
        cur_req = "R3";
        set_alloc(1, 0, 'h101); step();
        set_ack(1); step();
        set_ack(1); step();
        set_rsp(1, 1, 2); step();

        // R3: one early ack, grant 2, last ack
        set_alloc(1, 0, 'h102); step();
        set_ack(1); step();
        set_rsp(1, 0, 2); step();
        set_ack(1); step();

        // R4: zero-count grant
        cur_req = "R4";
        set_alloc(2, 0, 'h103); step();
        set_rsp(2, 0, 0); step();

        // R5 + R6: held intervention released on NACK
        cur_req = "R5";
        set_alloc(3, 0, 'h104); step();
        set_intv('h104); step();
        set_rsp(3, 2, 0); step();

        // R6 + R7: hold, refuse second, release on completion
        cur_req = "R6";
        set_alloc(0, 0, 'h200); step();
        set_intv('h200); step();
        cur_req = "R7";
        set_intv('h200); step();
        cur_req = "R6";
        set_rsp(0, 0, 1); step();
        set_ack(0); step();

        // R6: intervention arriving in the closing cycle
        set_alloc(0, 0, 'h210); step();
        set_rsp(0, 1, 1); step();
        set_ack(0); set_intv('h210); step();

        // R8 + R9: writeback and store on the same line; drop wins
        cur_req = "R8";
        set_alloc(1, 1, 'h300); step();
        set_alloc(2, 0, 'h300); step();
        set_intv('h300); step();
        cur_req = "R9";
        set_rsp(1, 3, 0); step();
        cur_req = "R8";
        set_intv('h300); step();
        set_rsp(2, 0, 0); step();

        // R10: unmatched interventions
        cur_req = "R10";
        set_intv('h3ff); step();
        set_intv('h0); step();

        // R11: busy allocation ignored, stray ack/response ignored
        cur_req = "R11";
        set_alloc(0, 0, 'h400); step();
        set_alloc(0, 1, 'h401); step();
        set_intv('h401); step();
        set_rsp(0, 3, 0); step();
        set_ack(3); step();
        set_rsp(3, 0, 0); step();
        set_alloc(3, 0, 'h402); step();
        set_rsp(3, 0, 1); step();
        set_rsp(3, 0, 0); step();
        set_ack(3); step();
        set_rsp(0, 0, 0); step();

        // R12: two entries close in the same cycle
        cur_req = "R12";
        set_alloc(0, 0, 'h500); step();
        set_alloc(1, 0, 'h501); step();
        set_rsp(0, 0, 1); step();
        set_ack(0); set_rsp(1, 1, 0); step();
        set_alloc(2, 1, 'h502); step();
        set_alloc(3, 0, 'h503); step();
        set_rsp(2, 3, 0); step();
        set_rsp(3, 0, 0); step();
        step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule